// File: doc/BRIEF.md
# Keyboard Data Port with Mode Control

This block sits between a keyboard receiver and a host's parallel I/O space. It holds the most recent scan code in one latch and raises an interrupt line when a code arrives. A read strobe on the data port either returns that code or returns a fixed switch value. A two-bit mode field in the upper bits of a system control byte sets how the block treats incoming codes and the interrupt. In one mode the block accepts codes. In another it drops every code. Two modes lower the interrupt, and two modes start a keyboard reset.

A keyboard reset is timed against a slow tick input. When the countdown finishes, the block loads the self-test-pass code 0xAA as though the keyboard had sent it. The upper mode bit also acts as the read enable. While it is set, the data port returns the fixed value 0x3D and the latch is left untouched. The serial line protocol to the keyboard and any scan-code translation happen upstream of this block.

Top module: `kbd_mode_port`

## Requirements
- R1: After reset the mode is 01 (bits 7..6 of the control byte), `irq` is low, and `rd_data` reads 0x00.
- R2: In mode 01, a `key_valid` pulse latches the code and raises `irq` at the next clock edge. From then on `rd_data` shows the code.
- R3: The latched code is `{key_release, key_scan[6:0]}`. Bit 7 is set for a key release and clear for a press.
- R4: Writing mode 11 lowers `irq`. While the mode is 11, incoming codes change neither the latch nor `irq`.
- R5: Writing mode 10 lowers `irq` and starts a keyboard reset. When the reset completes, 0xAA is latched and `irq` is raised.
- R6: Writing mode 00 starts a keyboard reset but leaves `irq` and the latch unchanged.
- R7: A reset completes on exactly the 5th clock in which `tick` is high after the mode write. Cycles without `tick` do not count.
- R8: A control write that keeps the same mode does not restart a running countdown. A reset starts only when the new mode (00 or 10) differs from the current mode.
- R9: When bit 7 of the mode is 0, a `rd_stb` read returns the latch on `rd_data`, then clears the latch to 0x00 and lowers `irq`.
- R10: When bit 7 of the mode is 1, `rd_data` returns 0x3D, and a read changes neither the latch nor `irq`.
- R11: A new code that arrives while the latch is full overwrites it.
- R12: An accepted code takes priority over a clear in the same cycle. A read in that cycle returns the old code, and a control write in that cycle judges acceptance by the mode before the write.
- R13: A self-test code that completes while the mode is 11 is discarded. If it completes in the same cycle as a keyboard code, the 0xAA is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_data | input | 8 | Control byte; bits 7..6 carry the mode |
| tick | input | 1 | Timebase for the reset countdown |
| key_valid | input | 1 | A code from the keyboard receiver is present |
| key_scan | input | 7 | Key number |
| key_release | input | 1 | 1 for a release, 0 for a press |
| rd_stb | input | 1 | Data port read strobe |
| rd_data | output | 8 | Data port value |
| irq | output | 1 | Keyboard interrupt request |

## Verification
Two functions can fall in the same clock: setting the latch, from a keyboard code or a completed self-test, and clearing it, from a data read or a mode write that lowers the interrupt. The bench provokes this by driving `key_valid` together with `rd_stb`, and again together with a mode-11 write. It also times `key_valid` to land on the tick that completes a reset. In each case the bench judges the result by the value returned during the read, then the `irq` level and the latch contents after the edge. The latch contents are shown by switching back to mode 01.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;

  typedef enum logic [1:0] {
    KM_RESET_KEEP = 2'b00,
    KM_NORMAL     = 2'b01,
    KM_RESET_CLR  = 2'b10,
    KM_DISCARD    = 2'b11
  } kbd_mode_e;

  localparam int unsigned KBD_CODE_W     = 8;
  localparam int unsigned KBD_CTRL_W     = 8;
  localparam int unsigned KBD_RESET_TICKS = 5;

endpackage

// File: rtl/kbd_mode_reg.sv
module kbd_mode_reg
  import kbd_port_pkg::*;
#(
  parameter int unsigned CTRL_W = KBD_CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_data,
  output kbd_mode_e         mode_q,
  output logic              reset_start,
  output logic              irq_clear,
  output logic              discard,
  output logic              rd_enable
);

  localparam int unsigned MODE_HI = CTRL_W - 1;
  localparam int unsigned MODE_LO = CTRL_W - 2;

  kbd_mode_e mode_wr;
  kbd_mode_e mode_d;
  logic      mode_en;

  always_comb begin
    mode_wr     = kbd_mode_e'(ctrl_data[MODE_HI:MODE_LO]);
    mode_en     = ctrl_we;
    mode_d      = mode_en ? mode_wr : mode_q;
    reset_start = ctrl_we && !mode_wr[0] && (mode_wr != mode_q);
    irq_clear   = ctrl_we && mode_wr[1];
    discard     = (mode_q == KM_DISCARD);
    rd_enable   = !mode_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= KM_NORMAL;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/kbd_reset_timer.sv
module kbd_reset_timer #(
  parameter int unsigned RESET_TICKS = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic                                 tick,
  output logic [$clog2(RESET_TICKS+1)-1:0]    cnt_q,
  output logic                                 done
);

  localparam int unsigned CNT_W = $clog2(RESET_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESET_TICKS);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             busy;

  always_comb begin
    busy   = (cnt_q != '0);
    done   = tick && !start && (cnt_q == CNT_ONE);
    cnt_en = start || (tick && busy);
    if (start) begin
      cnt_d = CNT_LOAD;
    end else begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/kbd_code_latch.sv
module kbd_code_latch #(
  parameter int unsigned     CODE_W   = 8,
  parameter logic [CODE_W-1:0] SELFTEST = 'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              discard,
  input  logic              selftest_post,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_in,
  input  logic              rd_stb,
  input  logic              rd_enable,
  input  logic              irq_clear,
  output logic [CODE_W-1:0] latch_q,
  output logic              irq_q
);

  logic [CODE_W-1:0] latch_d;
  logic              irq_d;
  logic              latch_en;

  always_comb begin
    latch_d = latch_q;
    irq_d   = irq_q;
    if (!discard && selftest_post) begin
      latch_d = SELFTEST;
      irq_d   = 1'b1;
    end else if (!discard && code_valid) begin
      latch_d = code_in;
      irq_d   = 1'b1;
    end else begin
      if (rd_stb && rd_enable) begin
        latch_d = '0;
        irq_d   = 1'b0;
      end
      if (irq_clear) begin
        irq_d = 1'b0;
      end
    end
    latch_en = (latch_d != latch_q) || (irq_d != irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      irq_q   <= 1'b0;
    end else if (latch_en) begin
      latch_q <= latch_d;
      irq_q   <= irq_d;
    end
  end

endmodule

// File: rtl/kbd_mode_port.sv
module kbd_mode_port
  import kbd_port_pkg::*;
#(
  parameter int unsigned       CODE_W      = KBD_CODE_W,
  parameter int unsigned       CTRL_W      = KBD_CTRL_W,
  parameter int unsigned       RESET_TICKS = KBD_RESET_TICKS,
  parameter logic [CODE_W-1:0] SELFTEST    = 'hAA,
  parameter logic [CODE_W-1:0] LOCKED_VAL  = 'h3D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_data,
  input  logic              tick,
  input  logic              key_valid,
  input  logic [CODE_W-2:0] key_scan,
  input  logic              key_release,
  input  logic              rd_stb,
  output logic [CODE_W-1:0] rd_data,
  output logic              irq
);

  localparam int unsigned CNT_W = $clog2(RESET_TICKS + 1);

  kbd_mode_e         mode_q;
  logic              reset_start;
  logic              irq_clear;
  logic              discard;
  logic              rd_enable;
  logic [CNT_W-1:0]  rst_cnt;
  logic              selftest_post;
  logic [CODE_W-1:0] code_in;
  logic [CODE_W-1:0] latch_q;

  assign code_in = {key_release, key_scan};

  kbd_mode_reg #(
    .CTRL_W(CTRL_W)
  ) i_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_data  (ctrl_data),
    .mode_q     (mode_q),
    .reset_start(reset_start),
    .irq_clear  (irq_clear),
    .discard    (discard),
    .rd_enable  (rd_enable)
  );

  kbd_reset_timer #(
    .RESET_TICKS(RESET_TICKS)
  ) i_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(reset_start),
    .tick (tick),
    .cnt_q(rst_cnt),
    .done (selftest_post)
  );

  kbd_code_latch #(
    .CODE_W  (CODE_W),
    .SELFTEST(SELFTEST)
  ) i_latch (
    .clk          (clk),
    .rst_n        (rst_n),
    .discard      (discard),
    .selftest_post(selftest_post),
    .code_valid   (key_valid),
    .code_in      (code_in),
    .rd_stb       (rd_stb),
    .rd_enable    (rd_enable),
    .irq_clear    (irq_clear),
    .latch_q      (latch_q),
    .irq_q        (irq)
  );

  always_comb begin
    rd_data = rd_enable ? latch_q : LOCKED_VAL;
  end

endmodule

// File: rtl/kbd_mode_port_chk.sv
module kbd_mode_port_chk
  import kbd_port_pkg::*;
#(
  parameter int unsigned CODE_W      = KBD_CODE_W,
  parameter int unsigned CTRL_W      = KBD_CTRL_W,
  parameter int unsigned RESET_TICKS = KBD_RESET_TICKS,
  parameter int unsigned CNT_W       = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_we,
  input logic [CTRL_W-1:0] ctrl_data,
  input logic              key_valid,
  input logic [CODE_W-2:0] key_scan,
  input logic              key_release,
  input logic              rd_stb,
  input logic              irq,
  input kbd_mode_e         mode_q,
  input logic [CODE_W-1:0] latch_q,
  input logic              selftest_post,
  input logic [CNT_W-1:0]  rst_cnt
);

  logic live_key;
  logic live_post;
  assign live_key  = key_valid && (mode_q != KM_DISCARD);
  assign live_post = selftest_post && (mode_q != KM_DISCARD);

  AST_CODE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    live_key && !selftest_post |=> irq && (latch_q == $past({key_release, key_scan}))); // R2

  AST_DISCARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == KM_DISCARD) |=> $stable(latch_q)); // R4

  AST_DISCARD_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == KM_DISCARD) && !irq |=> !irq); // R4

  AST_CTRL_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && ctrl_data[CTRL_W-1] && !live_key && !live_post |=> !irq); // R5

  AST_POST_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    live_post |=> irq && (latch_q == CODE_W'('hAA))); // R5

  AST_MODE00_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && (ctrl_data[CTRL_W-1 -: 2] == 2'b00) && irq && !rd_stb |=> irq); // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cnt <= CNT_W'(RESET_TICKS)); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !mode_q[1] && !key_valid && !selftest_post |=> (latch_q == '0) && !irq); // R9

  AST_LOCKED_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] && !key_valid && !selftest_post && !ctrl_we |=> $stable(latch_q) && $stable(irq)); // R10

endmodule

bind kbd_mode_port kbd_mode_port_chk #(
  .CODE_W     (CODE_W),
  .CTRL_W     (CTRL_W),
  .RESET_TICKS(RESET_TICKS),
  .CNT_W      (CNT_W)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_we      (ctrl_we),
  .ctrl_data    (ctrl_data),
  .key_valid    (key_valid),
  .key_scan     (key_scan),
  .key_release  (key_release),
  .rd_stb       (rd_stb),
  .irq          (irq),
  .mode_q       (mode_q),
  .latch_q      (latch_q),
  .selftest_post(selftest_post),
  .rst_cnt      (rst_cnt)
);

// File: tb/test_kbd_mode_port.sv
module test_kbd_mode_port;

  logic       clk;
  logic       rst_n;
  logic       ctrl_we;
  logic [7:0] ctrl_data;
  logic       tick;
  logic       key_valid;
  logic [6:0] key_scan;
  logic       key_release;
  logic       rd_stb;
  logic [7:0] rd_data;
  logic       irq;

  int checks;
  int failures;
  bit done;

  kbd_mode_port i_kbd_mode_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_data  (ctrl_data),
    .tick       (tick),
    .key_valid  (key_valid),
    .key_scan   (key_scan),
    .key_release(key_release),
    .rd_stb     (rd_stb),
    .rd_data    (rd_data),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] b);
    ctrl_we = 1'b1; ctrl_data = b;
    cyc();
    ctrl_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] c);
    key_valid = 1'b1; key_release = c[7]; key_scan = c[6:0];
    cyc();
    key_valid = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    rd_stb = 1'b1;
    v = rd_data;
    cyc();
    rd_stb = 1'b0;
  endtask

  task automatic one_tick();
    tick = 1'b1;
    cyc();
    tick = 1'b0;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] exp;
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_data = '0; tick = 1'b0;
    key_valid = 1'b0; key_scan = '0; key_release = 1'b0; rd_stb = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);

    // R2 R3 R9: every key, pressed and released
    for (int k = 0; k < 128; k++) begin
      for (int r = 0; r < 2; r++) begin
        exp = {r[0], k[6:0]};
        send(exp);
        chk("R2 irq", {7'b0, irq}, 8'h01);
        chk("R3 code", rd_data, exp);
        do_read(v);
        chk("R9 read", v, exp);
        chk("R9 cleared", rd_data, 8'h00);
        chk("R9 irq", {7'b0, irq}, 8'h00);
      end
    end

    // R11 overwrite
    send(8'h1E); send(8'h9F);
    do_read(v);
    chk("R11 overwrite", v, 8'h9F);

    // R4 discard mode
    send(8'h12);
    wr_ctrl(8'hC0);
    chk("R4 irq lowered", {7'b0, irq}, 8'h00);
    chk("R10 locked value", rd_data, 8'h3D);
    send(8'h34);
    chk("R4 irq stays low", {7'b0, irq}, 8'h00);
    do_read(v);
    chk("R10 read value", v, 8'h3D);
    wr_ctrl(8'h40);
    chk("R4 latch kept", rd_data, 8'h12);
    chk("R10 read had no effect", rd_data, 8'h12);
    do_read(v);
    chk("R9 read back", v, 8'h12);

    // R5 R7 R8 reset with irq clear
    send(8'h21);
    wr_ctrl(8'h80);
    chk("R5 irq lowered", {7'b0, irq}, 8'h00);
    one_tick(); one_tick();
    chk("R7 early", {7'b0, irq}, 8'h00);
    wr_ctrl(8'h80);
    one_tick(); cyc(); cyc();
    chk("R8 tick3", {7'b0, irq}, 8'h00);
    one_tick();
    chk("R7 tick4", {7'b0, irq}, 8'h00);
    one_tick();
    chk("R7 tick5 irq", {7'b0, irq}, 8'h01);
    wr_ctrl(8'h40);
    chk("R5 selftest code", rd_data, 8'hAA);
    do_read(v);
    chk("R5 read selftest", v, 8'hAA);

    // R6 reset without clear
    send(8'h33);
    wr_ctrl(8'h00);
    chk("R6 irq kept", {7'b0, irq}, 8'h01);
    for (int t = 0; t < 4; t++) one_tick();
    chk("R6 latch kept", rd_data, 8'h33);
    one_tick();
    chk("R6 selftest", rd_data, 8'hAA);
    do_read(v);
    chk("R6 read", v, 8'hAA);
    wr_ctrl(8'h00);
    for (int t = 0; t < 6; t++) one_tick();
    chk("R8 no restart irq", {7'b0, irq}, 8'h00);
    chk("R8 no restart data", rd_data, 8'h00);

    // R13 selftest discarded in mode 11
    wr_ctrl(8'h40);
    wr_ctrl(8'h80);
    one_tick(); one_tick();
    wr_ctrl(8'hC0);
    for (int t = 0; t < 3; t++) one_tick();
    chk("R13 discard irq", {7'b0, irq}, 8'h00);
    wr_ctrl(8'h40);
    chk("R13 discard data", rd_data, 8'h00);

    // R13 selftest vs key in same cycle
    wr_ctrl(8'h00);
    for (int t = 0; t < 4; t++) one_tick();
    tick = 1'b1; key_valid = 1'b1; key_scan = 7'h05; key_release = 1'b0;
    cyc();
    tick = 1'b0; key_valid = 1'b0;
    chk("R13 collision", rd_data, 8'hAA);
    do_read(v);
    wr_ctrl(8'h40);

    // R12 read and key in same cycle
    send(8'h11);
    rd_stb = 1'b1; key_valid = 1'b1; key_scan = 7'h22; key_release = 1'b0;
    v = rd_data;
    cyc();
    rd_stb = 1'b0; key_valid = 1'b0;
    chk("R12 read old", v, 8'h11);
    chk("R12 irq", {7'b0, irq}, 8'h01);
    chk("R12 new code", rd_data, 8'h22);

    // R12 mode-11 write and key in same cycle
    ctrl_we = 1'b1; ctrl_data = 8'hC0;
    key_valid = 1'b1; key_scan = 7'h44; key_release = 1'b0;
    cyc();
    ctrl_we = 1'b0; key_valid = 1'b0;
    chk("R12 write irq", {7'b0, irq}, 8'h01);
    wr_ctrl(8'h40);
    chk("R12 write code", rd_data, 8'h44);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule